// File: doc/BRIEF.md
# DMA Descriptor Loop Address Engine

This block is one DMA channel that moves data between two regions of a byte-addressed memory under the control of a transfer descriptor. The descriptor is presented on static configuration inputs. It holds the following fields for each side (source and destination): a start address, a beat size, a signed per-beat step, a modulo window width and a signed adjustment applied at the end of the major loop. Two fields are shared by both sides: a byte count for each minor loop and a major-loop iteration count. A load strobe copies the start addresses and the iteration count into the working registers. After that, every request pulse moves one minor loop of data. The engine reads source beats into a staging register that is as wide as the widest beat, then drains it in destination-sized beats, and repeats until the byte count is used up.

The controller is a five-state machine. IDLE waits for work. READ issues a source read. CAPT captures the returned data. WRITE issues destination writes. CLOSE ends a minor loop. The transitions are as follows. Start goes from IDLE to READ on an accepted request. Fetch goes from READ to CAPT, always. Refill goes from CAPT back to READ while the staging unit is incomplete. Drain goes from CAPT to WRITE once it is full. Stay keeps WRITE in WRITE while the unit still holds bytes. Next goes from WRITE to READ when the unit is empty and bytes remain. Finish goes from WRITE to CLOSE on the last write. Return goes from CLOSE to IDLE. Reject keeps the machine in IDLE when the descriptor is inconsistent.

Top module: `dma_loop_engine`

## Requirements
- R1: After reset the engine is idle: busy, done, err and mem_en are 0, the iteration count is 0 and both working addresses are 0.
- R2: One accepted request moves exactly cfg_nbytes bytes: all reads of a staging unit come before its writes. The engine then returns to idle and does nothing more until the next request.
- R3: After each read beat the sign-extended source step is added to the source address, and after each write beat the destination step is added to the destination address. Negative steps walk downward.
- R4: Each completed minor loop lowers the iteration count by one while it is above 1.
- R5: The major loop ends in the closing cycle of a minor loop that starts with an iteration count of 1 (or 0). In that cycle done is high for exactly one cycle and each side's signed last-adjustment is added to its address. The iteration count is then reloaded from cfg_biter.
- R6: When a side's modulo width m is nonzero, a per-beat step changes only address bits [m-1:0] and holds all higher bits. A width of 0 disables the window. The end-of-major-loop adjustment is not windowed.
- R7: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Data on mem_rdata and mem_wdata is little-endian and right-justified. Read data is valid in the cycle after the read is issued. Bytes keep their order from source to destination whatever the two sizes are.
- R8: A request is rejected in any of these cases: either size code is 3, cfg_nbytes is 0, cfg_nbytes is not a multiple of both beat sizes, or cfg_biter is 0. A rejected request makes no memory access, leaves busy low, sets err and latches CHAN_ID on err_chan.
- R9: err_clr clears err and err_chan. A later request with the same bad descriptor sets them again.
- R10: A request that arrives while a minor loop runs is held. It starts the next minor loop as soon as the engine is back in IDLE, without another pulse.
- R11: busy is high from the cycle after an accepted request through the closing cycle of the minor loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request pulse, one minor loop each |
| cfg_load | input | 1 | Copy start addresses and iteration count into working registers (ignored while busy) |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_soff | input | OW | Signed source step per beat |
| cfg_doff | input | OW | Signed destination step per beat |
| cfg_ssize | input | 2 | Source beat size code |
| cfg_dsize | input | 2 | Destination beat size code |
| cfg_smod | input | MW | Source modulo window width in address bits |
| cfg_dmod | input | MW | Destination modulo window width in address bits |
| cfg_slast | input | AW | Signed source adjustment at major-loop end |
| cfg_dlast | input | AW | Signed destination adjustment at major-loop end |
| cfg_nbytes | input | NBW | Bytes per minor loop |
| cfg_biter | input | IW | Iteration count reload value |
| err_clr | input | 1 | Clear the error flag and channel field |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Size code of the access |
| mem_wdata | output | 32 | Right-justified write data |
| mem_rdata | input | 32 | Right-justified read data, one cycle after the read |
| busy | output | 1 | Minor loop in progress |
| done | output | 1 | One-cycle major-loop completion pulse |
| citer | output | IW | Current iteration count |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| err | output | 1 | Configuration error flag |
| err_chan | output | CHW | Channel number of the last rejected request |

## Verification
The hardest case to reach from the ports is a request that is held pending. Between the two loops busy drops for only one cycle, so the second loop has to start with no new pulse. The bench raises a second request while busy is high. It then waits a fixed span instead of waiting for busy to fall, and checks that the iteration count dropped by two and that both loops' bytes arrived. The error re-detection after a clear and the major-loop wrap are each reached by direct request sequences on one descriptor.

// File: rtl/dma_lp_pkg.sv
package dma_lp_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_CAPT,
        S_WRITE,
        S_CLOSE
    } loop_state_e;

    // beat size code to byte count
    function automatic logic [3:0] sz_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    // byte lane mask for a right-justified beat
    function automatic logic [DATA_W-1:0] sz_mask(input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        unique case (sz)
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_cfg_guard.sv
module dma_cfg_guard #(
    parameter int NBW     = 16,
    parameter int IW      = 12,
    parameter int CHW     = 4,
    parameter int CHAN_ID = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     ssize,
    input  logic [1:0]     dsize,
    input  logic [NBW-1:0] nbytes,
    input  logic [IW-1:0]  biter,
    input  logic           reject,
    input  logic           err_clr,
    output logic           cfg_ok,
    output logic           err,
    output logic [CHW-1:0] err_chan
);
    import dma_lp_pkg::*;

    logic [3:0]     s_b, d_b, unit_b;
    logic [NBW-1:0] frac;

    always_comb begin
        s_b    = sz_bytes(ssize);
        d_b    = sz_bytes(dsize);
        unit_b = (s_b > d_b) ? s_b : d_b;
        frac   = nbytes & NBW'(unit_b - 4'd1);
        cfg_ok = (ssize != 2'd3) && (dsize != 2'd3) &&
                 (nbytes != '0) && (biter != '0) && (frac == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err      <= 1'b0;
            err_chan <= '0;
        end else if (reject) begin
            err      <= 1'b1;
            err_chan <= CHW'(CHAN_ID);
        end else if (err_clr) begin
            err      <= 1'b0;
            err_chan <= '0;
        end
    end

    // R8: a rejected request always leaves the error flag set
    p_reject_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (err && err_chan == CHW'(CHAN_ID)));

endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side #(
    parameter int AW = 32,
    parameter int OW = 16,
    parameter int MW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic [OW-1:0] off,
    input  logic [MW-1:0] modw,
    input  logic          wrap,
    input  logic [AW-1:0] last,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] off_ext;
    logic [AW-1:0] win_mask;
    logic [AW-1:0] stepped;
    logic [AW-1:0] addr_nxt;

    always_comb begin
        off_ext  = {{(AW-OW){off[OW-1]}}, off};
        win_mask = (modw == '0) ? '1 : ((AW'(1) << modw) - AW'(1));
        stepped  = addr + off_ext;
        addr_nxt = addr;
        if (load)
            addr_nxt = load_addr;
        else if (wrap)
            addr_nxt = addr + last;
        else if (step)
            addr_nxt = (addr & ~win_mask) | (stepped & win_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else
            addr <= addr_nxt;
    end

    // R6: a windowed step never disturbs bits above the window
    p_mod_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !wrap) |=>
            ((addr & ~$past(win_mask)) == ($past(addr) & ~$past(win_mask))));

    // R2: the address is frozen when no update source is active
    p_addr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load && !wrap) |=> $stable(addr));

endmodule

// File: rtl/dma_loop_fsm.sv
module dma_loop_fsm #(
    parameter int NBW = 16,
    parameter int IW  = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic                          cfg_ok,
    input  logic                          load,
    input  logic [1:0]                    ssize,
    input  logic [1:0]                    dsize,
    input  logic [NBW-1:0]                nbytes,
    input  logic [IW-1:0]                 biter,
    input  logic [dma_lp_pkg::DATA_W-1:0] mem_rdata,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [1:0]                    mem_size,
    output logic [dma_lp_pkg::DATA_W-1:0] mem_wdata,
    output logic                          s_step,
    output logic                          d_step,
    output logic                          wrap,
    output logic                          reject,
    output logic                          busy,
    output logic                          done,
    output logic [IW-1:0]                 citer
);
    import dma_lp_pkg::*;

    loop_state_e          state, nxt;
    logic                 pend;
    logic [NBW-1:0]       left;
    logic [3:0]           rpos, wpos;
    logic [1:0]           sz_s, sz_d;
    logic [3:0]           unit_q;
    logic [DATA_W-1:0]    stage;
    logic                 start_req;
    logic                 accept;
    logic [3:0]           sb, db;
    logic [3:0]           rpos_n, wpos_n;
    logic [NBW-1:0]       left_n;
    logic                 unit_full, unit_empty, last_wr;
    logic [DATA_W-1:0]    rd_bits;
    logic [3:0]           s_b_cfg, d_b_cfg;

    always_comb begin
        start_req  = req || pend;
        accept     = (state == S_IDLE) && start_req && cfg_ok;
        sb         = sz_bytes(sz_s);
        db         = sz_bytes(sz_d);
        rpos_n     = rpos + sb;
        wpos_n     = wpos + db;
        left_n     = left - NBW'(db);
        unit_full  = (rpos_n == unit_q);
        unit_empty = (wpos_n == unit_q);
        last_wr    = unit_empty && (left_n == '0);
        rd_bits    = mem_rdata & sz_mask(sz_s);
        s_b_cfg    = sz_bytes(ssize);
        d_b_cfg    = sz_bytes(dsize);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (accept) nxt = S_READ;
            S_READ:  nxt = S_CAPT;
            S_CAPT:  nxt = unit_full ? S_WRITE : S_READ;
            S_WRITE: begin
                if (last_wr)
                    nxt = S_CLOSE;
                else if (unit_empty)
                    nxt = S_READ;
                else
                    nxt = S_WRITE;
            end
            S_CLOSE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // loop counters, staging and iteration count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            left   <= '0;
            rpos   <= '0;
            wpos   <= '0;
            sz_s   <= '0;
            sz_d   <= '0;
            unit_q <= 4'd1;
            stage  <= '0;
            citer  <= '0;
        end else begin
            if (state == S_IDLE)
                pend <= 1'b0;
            else if (req)
                pend <= 1'b1;

            if (load && state == S_IDLE)
                citer <= biter;

            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        left   <= nbytes;
                        rpos   <= '0;
                        wpos   <= '0;
                        sz_s   <= ssize;
                        sz_d   <= dsize;
                        unit_q <= (s_b_cfg > d_b_cfg) ? s_b_cfg : d_b_cfg;
                    end
                end
                S_READ: ;
                S_CAPT: begin
                    if (rpos == '0)
                        stage <= rd_bits;
                    else
                        stage <= stage | (rd_bits << {rpos, 3'b000});
                    rpos <= unit_full ? '0 : rpos_n;
                end
                S_WRITE: begin
                    left <= left_n;
                    wpos <= unit_empty ? '0 : wpos_n;
                end
                S_CLOSE: begin
                    if (citer <= IW'(1))
                        citer <= biter;
                    else
                        citer <= citer - IW'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy      = (state != S_IDLE);
        mem_en    = (state == S_READ) || (state == S_WRITE);
        mem_we    = (state == S_WRITE);
        mem_size  = (state == S_WRITE) ? sz_d : sz_s;
        mem_wdata = (stage >> {wpos, 3'b000}) & sz_mask(sz_d);
        s_step    = (state == S_READ);
        d_step    = (state == S_WRITE);
        done      = (state == S_CLOSE) && (citer <= IW'(1));
        wrap      = done;
        reject    = (state == S_IDLE) && start_req && !cfg_ok;
    end

    // R4: one decrement per closed minor loop
    p_citer_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLOSE && citer > IW'(1)) |=> (citer == $past(citer) - IW'(1)));

    // R5: major-loop end reloads the iteration count
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (citer == $past(biter)));

    // R8: a rejected request starts nothing
    p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (state == S_IDLE));

    // R10: a request seen near the end of a loop is kept for the next one
    p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLOSE && req) |=> (state == S_IDLE && pend));

    // R11: an accepted request raises busy on the next cycle
    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine #(
    parameter int AW      = 32,
    parameter int OW      = 16,
    parameter int MW      = 5,
    parameter int NBW     = 16,
    parameter int IW      = 12,
    parameter int CHW     = 4,
    parameter int CHAN_ID = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           cfg_load,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [OW-1:0]  cfg_soff,
    input  logic [OW-1:0]  cfg_doff,
    input  logic [1:0]     cfg_ssize,
    input  logic [1:0]     cfg_dsize,
    input  logic [MW-1:0]  cfg_smod,
    input  logic [MW-1:0]  cfg_dmod,
    input  logic [AW-1:0]  cfg_slast,
    input  logic [AW-1:0]  cfg_dlast,
    input  logic [NBW-1:0] cfg_nbytes,
    input  logic [IW-1:0]  cfg_biter,
    input  logic           err_clr,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    output logic           busy,
    output logic           done,
    output logic [IW-1:0]  citer,
    output logic [AW-1:0]  src_addr,
    output logic [AW-1:0]  dst_addr,
    output logic           err,
    output logic [CHW-1:0] err_chan
);
    logic cfg_ok, reject, s_step, d_step, wrap, ld;

    assign ld       = cfg_load && !busy;
    assign mem_addr = mem_we ? dst_addr : src_addr;

    dma_cfg_guard #(.NBW(NBW), .IW(IW), .CHW(CHW), .CHAN_ID(CHAN_ID)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .ssize    (cfg_ssize),
        .dsize    (cfg_dsize),
        .nbytes   (cfg_nbytes),
        .biter    (cfg_biter),
        .reject   (reject),
        .err_clr  (err_clr),
        .cfg_ok   (cfg_ok),
        .err      (err),
        .err_chan (err_chan)
    );

    dma_loop_fsm #(.NBW(NBW), .IW(IW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .cfg_ok    (cfg_ok),
        .load      (ld),
        .ssize     (cfg_ssize),
        .dsize     (cfg_dsize),
        .nbytes    (cfg_nbytes),
        .biter     (cfg_biter),
        .mem_rdata (mem_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .s_step    (s_step),
        .d_step    (d_step),
        .wrap      (wrap),
        .reject    (reject),
        .busy      (busy),
        .done      (done),
        .citer     (citer)
    );

    dma_addr_side #(.AW(AW), .OW(OW), .MW(MW)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_addr (cfg_src),
        .step      (s_step),
        .off       (cfg_soff),
        .modw      (cfg_smod),
        .wrap      (wrap),
        .last      (cfg_slast),
        .addr      (src_addr)
    );

    dma_addr_side #(.AW(AW), .OW(OW), .MW(MW)) u_dst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_addr (cfg_dst),
        .step      (d_step),
        .off       (cfg_doff),
        .modw      (cfg_dmod),
        .wrap      (wrap),
        .last      (cfg_dlast),
        .addr      (dst_addr)
    );

    // R2: memory is only touched inside a minor loop
    p_mem_in_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

endmodule

// File: tb/dma_loop_engine_test.sv
`timescale 1ns/1ps
module dma_loop_engine_test;
    localparam int CH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, cfg_load = 1'b0, err_clr = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_slast = '0, cfg_dlast = '0;
    logic [15:0] cfg_soff = '0, cfg_doff = '0, cfg_nbytes = '0;
    logic [1:0]  cfg_ssize = '0, cfg_dsize = '0;
    logic [4:0]  cfg_smod = '0, cfg_dmod = '0;
    logic [11:0] cfg_biter = '0;
    logic        mem_en, mem_we, busy, done, err;
    logic [31:0] mem_addr, mem_wdata, src_addr, dst_addr;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  mem_size;
    logic [11:0] citer;
    logic [3:0]  err_chan;

    int checks = 0, errors = 0, cyc = 0, done_cnt = 0, acc_cnt = 0;
    logic [7:0] mem [0:255];

    always #2 clk = ~clk;

    dma_loop_engine #(.CHAN_ID(CH)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_load(cfg_load),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_soff(cfg_soff), .cfg_doff(cfg_doff),
        .cfg_ssize(cfg_ssize), .cfg_dsize(cfg_dsize), .cfg_smod(cfg_smod), .cfg_dmod(cfg_dmod),
        .cfg_slast(cfg_slast), .cfg_dlast(cfg_dlast), .cfg_nbytes(cfg_nbytes),
        .cfg_biter(cfg_biter), .err_clr(err_clr), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .citer(citer),
        .src_addr(src_addr), .dst_addr(dst_addr), .err(err), .err_chan(err_chan)
    );

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 3) + 1);
    endfunction

    // byte memory model, right-justified little-endian data, one-cycle read
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_byte(i);
        end else if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < (1 << mem_size); b++)
                    mem[8'(mem_addr + 32'(b))] <= mem_wdata[8*b +: 8];
            end else begin
                logic [31:0] d;
                d = '0;
                for (int b = 0; b < (1 << mem_size); b++)
                    d[8*b +: 8] = mem[8'(mem_addr + 32'(b))];
                mem_rdata <= d;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        if (mem_en) acc_cnt++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_copy(input string tag, input int dst, input int src, input int n);
        for (int i = 0; i < n; i++)
            chk(tag, 32'(mem[8'(dst + i)]), 32'(init_byte(src + i)));
    endtask

    task automatic setup(input int src, input int dst, input int ss, input int ds,
                         input int so, input int dof, input int nb, input int bi);
        @(negedge clk);
        cfg_src = 32'(src); cfg_dst = 32'(dst);
        cfg_ssize = 2'(ss); cfg_dsize = 2'(ds);
        cfg_soff = 16'(so); cfg_doff = 16'(dof);
        cfg_nbytes = 16'(nb); cfg_biter = 12'(bi);
        cfg_smod = '0; cfg_dmod = '0; cfg_slast = '0; cfg_dlast = '0;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic pulse_req();
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic run_loop();
        @(negedge clk);
        pulse_req();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 mem_en", 32'(mem_en), 0);
        chk("R1 citer", 32'(citer), 0);
        chk("R1 src", src_addr, 0);
        chk("R1 dst", dst_addr, 0);
    endtask

    task automatic t_word_copy();
        setup(16'h10, 16'h80, 2, 2, 4, 4, 8, 3);
        run_loop();
        chk_copy("R2 word copy", 16'h80, 16'h10, 8);
        chk("R3 src step", src_addr, 32'h18);
        chk("R3 dst step", dst_addr, 32'h88);
        chk("R4 citer", 32'(citer), 2);
        repeat (3) @(negedge clk);
        chk("R2 stays idle", 32'(busy), 0);
    endtask

    task automatic t_major_end();
        int d0;
        setup(16'h20, 16'hA0, 2, 2, 4, 4, 8, 2);
        cfg_slast = 32'hFFFF_FFF0; cfg_dlast = 32'hFFFF_FFF0;
        d0 = done_cnt;
        run_loop();
        chk("R4 citer first", 32'(citer), 1);
        chk("R5 no early done", 32'(done_cnt - d0), 0);
        run_loop();
        chk("R5 one done pulse", 32'(done_cnt - d0), 1);
        chk("R5 citer reload", 32'(citer), 2);
        chk("R5 src wrap", src_addr, 32'h20);
        chk("R5 dst wrap", dst_addr, 32'hA0);
    endtask

    task automatic t_pack();
        setup(16'h30, 16'hB0, 0, 2, 1, 4, 8, 4);
        run_loop();
        chk_copy("R7 byte to word", 16'hB0, 16'h30, 8);
        chk("R7 src", src_addr, 32'h38);
        chk("R7 dst", dst_addr, 32'hB8);
        setup(16'h38, 16'hC0, 2, 1, 4, 2, 4, 4);
        run_loop();
        chk_copy("R7 word to half", 16'hC0, 16'h38, 4);
        chk("R7 dst half", dst_addr, 32'hC4);
    endtask

    task automatic t_modulo();
        setup(16'h40, 16'hD0, 2, 2, 4, 4, 16, 4);
        cfg_smod = 5'd3;
        run_loop();
        chk_copy("R6 window a", 16'hD0, 16'h40, 8);
        chk_copy("R6 window b", 16'hD8, 16'h40, 8);
        chk("R6 src held", src_addr, 32'h40);
        chk("R6 dst", dst_addr, 32'hE0);
    endtask

    task automatic t_neg_step();
        setup(16'h50, 16'hEF, 0, 0, 1, -1, 4, 4);
        run_loop();
        for (int i = 0; i < 4; i++)
            chk("R3 descending", 32'(mem[8'(16'hEF - i)]), 32'(init_byte(16'h50 + i)));
        chk("R3 dst down", dst_addr, 32'hEB);
    endtask

    task automatic t_errors();
        int a0;
        logic [11:0] c0;
        setup(16'h10, 16'h80, 3, 2, 4, 4, 8, 4);
        a0 = acc_cnt; c0 = citer;
        run_loop();
        chk("R8 err set", 32'(err), 1);
        chk("R8 err chan", 32'(err_chan), CH);
        chk("R8 no access", 32'(acc_cnt - a0), 0);
        chk("R8 citer kept", 32'(citer), 32'(c0));
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk("R9 cleared", 32'(err), 0);
        chk("R9 chan cleared", 32'(err_chan), 0);
        run_loop();
        chk("R9 detected again", 32'(err), 1);
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        cfg_ssize = 2'd2; cfg_nbytes = 16'd6;
        run_loop();
        chk("R8 nbytes not multiple", 32'(err), 1);
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        cfg_nbytes = 16'd0;
        run_loop();
        chk("R8 nbytes zero", 32'(err), 1);
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        cfg_nbytes = 16'd8; cfg_biter = '0;
        run_loop();
        chk("R8 biter zero", 32'(err), 1);
        chk("R8 no access total", 32'(acc_cnt - a0), 0);
        @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic t_pending();
        setup(16'h10, 16'hF0, 2, 2, 4, 4, 4, 5);
        @(negedge clk);
        pulse_req();
        chk("R11 busy after accept", 32'(busy), 1);
        pulse_req();
        repeat (30) @(negedge clk);
        chk("R10 two loops", 32'(citer), 3);
        chk("R10 dst advanced", dst_addr, 32'hF8);
        chk_copy("R10 data", 16'hF0, 16'h10, 8);
        chk("R11 busy low", 32'(busy), 0);
        chk("R10 no extra error", 32'(err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_copy();
        t_major_end();
        t_pack();
        t_modulo();
        t_neg_step();
        t_errors();
        t_pending();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule